// File: doc/BRIEF.md
# Reloadable 16-bit Interval Timer

This block is a down-counting interval timer. Its 16-bit counter is loaded from a pair of byte-wide reload latches. A small byte bus reaches the timer through four addresses, and a read and a write to the same address have different side effects. The counter moves only on cycles where the one-per-cycle `tick_i` input is high. At each time-out the timer sets an interrupt flag.

Two configuration inputs choose the behaviour at time-out:

- One-shot mode reports a single time-out for each load, and the counter then wraps and keeps counting.
- Free-run mode reloads the counter from the latches and keeps running.

An optional output pin shows the time-outs. In one-shot mode the pin is a low pulse that starts at load. In free-run mode the pin inverts at each time-out, which gives a square wave.

The address map is:

| Address | Write | Read |
|---|---|---|
| 0 | low latch | low counter byte (clears the flag) |
| 1 | high latch and counter load | high counter byte |
| 2 | low latch | low latch |
| 3 | high latch | high latch |

Top module: `rtimer`

## Requirements
- R1: After reset, the counter and both latches read 0, `irq_flag_o` is 0 and `pin_o` is 1. No time-out occurs before the first load, however many ticks arrive.
- R2: A write to address 0 or address 2 stores `wdata_i` in the low latch only. The counter and the flag keep their values.
- R3: A write to address 3 stores `wdata_i` in the high latch and clears the flag. The counter keeps its value.
- R4: A write to address 1 stores the high latch and loads the counter with {`wdata_i`, low latch}. It also clears the flag and arms the timer. A tick in the same cycle does not decrement the loaded value.
- R5: A read drives `rdata_o` in the same cycle: address 0 gives the low counter byte, 1 the high counter byte, 2 the low latch, and 3 the high latch. Only the read of address 0 clears the flag, on the following clock edge.
- R6: With `tick_i` high, the counter decrements by one per cycle, with borrow across the bytes. After a load of N, the (N+1)th tick is the time-out and sets the flag. A time-out in the same cycle as a clearing access leaves the flag set.
- R7: One-shot mode (`cfg_freerun_i`=0): after the time-out the counter wraps to 0xFFFF and keeps decrementing. It sets no further flag until the next load.
- R8: Free-run mode (`cfg_freerun_i`=1): at each time-out the counter reloads from the latches, so the flag is set again every N+1 ticks.
- R9: With `cfg_pin_en_i`=0, `pin_o` is 1. When the pin is enabled, a load drives the pin low. A time-out then drives it high in one-shot mode and inverts it in free-run mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Count enable, one pulse per count step |
| sel_i | input | 1 | Bus access valid this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | Register address 0..3 |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational |
| cfg_freerun_i | input | 1 | 1 = free-run, 0 = one-shot |
| cfg_pin_en_i | input | 1 | Enables the time-out output pin |
| irq_flag_o | output | 1 | Time-out interrupt flag |
| pin_o | output | 1 | Time-out output pin |

## Verification
The bound assertions check on every cycle the rules that hold in the cycle after an event:

- the exact counter value after a load;
- the reload value after a free-run time-out;
- the flag being set after any time-out;
- a clearing access leaving the flag low;
- a latch write leaving an idle counter unchanged;
- the disarming after a one-shot time-out;
- the pin inversion in free-run mode.

Some behaviours depend on long sequences and on what the bus reads back, so only the directed scenarios show them:

- the N+1 tick period;
- the wrap to 0xFFFF;
- silence after a one-shot time-out;
- set-over-clear in the same cycle;
- absence of side effects on reads of addresses 1 to 3.

// File: rtl/rtimer_pkg.sv
package rtimer_pkg;

  typedef enum logic [1:0] {
    REG_CNT_LO = 2'd0,
    REG_CNT_HI = 2'd1,
    REG_LAT_LO = 2'd2,
    REG_LAT_HI = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/rtimer_busdec.sv
module rtimer_busdec
  import rtimer_pkg::*;
(
  input  logic       sel_i,
  input  logic       we_i,
  input  logic [1:0] addr_i,
  output logic       wr_lat_lo_o,
  output logic       wr_lat_hi_o,
  output logic       load_o,
  output logic       clr_flag_o
);
  reg_sel_e rsel;
  logic     wr, rd;

  assign rsel = reg_sel_e'(addr_i);
  assign wr   = sel_i && we_i;
  assign rd   = sel_i && !we_i;

  always_comb begin
    wr_lat_lo_o = 1'b0;
    wr_lat_hi_o = 1'b0;
    load_o      = 1'b0;
    clr_flag_o  = 1'b0;
    if (wr) begin
      unique case (rsel)
        REG_CNT_LO, REG_LAT_LO: wr_lat_lo_o = 1'b1;
        REG_CNT_HI: begin
          wr_lat_hi_o = 1'b1;
          load_o      = 1'b1;
          clr_flag_o  = 1'b1;
        end
        REG_LAT_HI: begin
          wr_lat_hi_o = 1'b1;
          clr_flag_o  = 1'b1;
        end
        default: ;
      endcase
    end else if (rd && rsel == REG_CNT_LO) begin
      clr_flag_o = 1'b1;
    end
  end
endmodule

// File: rtl/rtimer_latch.sv
module rtimer_latch #(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [CNT_W-1:0]  latch_o
);
  logic [BYTE_W-1:0] lat_q [2];

  for (genvar b = 0; b < 2; b++) begin : g_byte
    logic wr_b;
    assign wr_b = (b == 0) ? wr_lo_i : wr_hi_i;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    lat_q[b] <= '0;
      else if (wr_b) lat_q[b] <= wdata_i;
    end
    assign latch_o[b*BYTE_W +: BYTE_W] = lat_q[b];
  end
endmodule

// File: rtl/rtimer_core.sv
module rtimer_core #(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             freerun_i,
  input  logic [CNT_W-1:0] latch_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             armed_o,
  output logic             timeout_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;

  function automatic logic [CNT_W-1:0] next_count(
    input logic [CNT_W-1:0] cur,
    input logic             tick,
    input logic             load,
    input logic [CNT_W-1:0] ld_val,
    input logic             reload,
    input logic [CNT_W-1:0] rl_val
  );
    if (load)        return ld_val;
    else if (reload) return rl_val;
    else if (tick)   return cur - CNT_W'(1);
    else             return cur;
  endfunction

  assign timeout_o = tick_i && armed_q && !load_i && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      cnt_q <= next_count(cnt_q, tick_i, load_i, load_val_i,
                          timeout_o && freerun_i, latch_i);
      if (load_i)                      armed_q <= 1'b1;
      else if (timeout_o && !freerun_i) armed_q <= 1'b0;
    end
  end

  assign cnt_o   = cnt_q;
  assign armed_o = armed_q;
endmodule

// File: rtl/rtimer_event.sv
module rtimer_event (
  input  logic clk,
  input  logic rst_n,
  input  logic timeout_i,
  input  logic clr_i,
  input  logic load_i,
  input  logic freerun_i,
  input  logic pin_en_i,
  output logic flag_o,
  output logic pin_state_o,
  output logic pin_o
);
  logic flag_q, pin_q;

  function automatic logic next_pin(input logic cur, input logic load,
                                    input logic tmo, input logic frun);
    if (load)     return 1'b0;
    else if (tmo) return frun ? !cur : 1'b1;
    else          return cur;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      pin_q  <= 1'b1;
    end else begin
      if (timeout_i)  flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
      pin_q <= next_pin(pin_q, load_i, timeout_i, freerun_i);
    end
  end

  assign flag_o      = flag_q;
  assign pin_state_o = pin_q;
  assign pin_o       = pin_en_i ? pin_q : 1'b1;
endmodule

// File: rtl/rtimer.sv
module rtimer
  import rtimer_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  input  logic              cfg_freerun_i,
  input  logic              cfg_pin_en_i,
  output logic              irq_flag_o,
  output logic              pin_o
);
  logic             wr_lat_lo, wr_lat_hi, ev_load, ev_clr, ev_timeout;
  logic             armed, pin_state;
  logic [CNT_W-1:0] latch_q, cnt, load_val;

  function automatic logic [BYTE_W-1:0] read_mux(
    input reg_sel_e         rs,
    input logic [CNT_W-1:0] c,
    input logic [CNT_W-1:0] l
  );
    unique case (rs)
      REG_CNT_LO: return c[BYTE_W-1:0];
      REG_CNT_HI: return c[CNT_W-1:BYTE_W];
      REG_LAT_LO: return l[BYTE_W-1:0];
      default:    return l[CNT_W-1:BYTE_W];
    endcase
  endfunction

  rtimer_busdec u_dec (
    .sel_i(sel_i), .we_i(we_i), .addr_i(addr_i),
    .wr_lat_lo_o(wr_lat_lo), .wr_lat_hi_o(wr_lat_hi),
    .load_o(ev_load), .clr_flag_o(ev_clr)
  );

  rtimer_latch #(.BYTE_W(BYTE_W)) u_lat (
    .clk(clk), .rst_n(rst_n), .wr_lo_i(wr_lat_lo), .wr_hi_i(wr_lat_hi),
    .wdata_i(wdata_i), .latch_o(latch_q)
  );

  assign load_val = {wdata_i, latch_q[BYTE_W-1:0]};

  rtimer_core #(.BYTE_W(BYTE_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .load_i(ev_load),
    .load_val_i(load_val), .freerun_i(cfg_freerun_i), .latch_i(latch_q),
    .cnt_o(cnt), .armed_o(armed), .timeout_o(ev_timeout)
  );

  rtimer_event u_evt (
    .clk(clk), .rst_n(rst_n), .timeout_i(ev_timeout), .clr_i(ev_clr),
    .load_i(ev_load), .freerun_i(cfg_freerun_i), .pin_en_i(cfg_pin_en_i),
    .flag_o(irq_flag_o), .pin_state_o(pin_state), .pin_o(pin_o)
  );

  assign rdata_o = (sel_i && !we_i) ? read_mux(reg_sel_e'(addr_i), cnt, latch_q) : '0;
endmodule

// File: rtl/rtimer_chk.sv
module rtimer_chk #(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_i,
  input logic [BYTE_W-1:0] wdata_i,
  input logic              cfg_freerun_i,
  input logic              cfg_pin_en_i,
  input logic              irq_flag_o,
  input logic              pin_o,
  input logic              wr_lat_lo,
  input logic              wr_lat_hi,
  input logic              ev_load,
  input logic              ev_clr,
  input logic              ev_timeout,
  input logic              armed,
  input logic              pin_state,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  latch_q
);
  a_r4_load_value: assert property (@(posedge clk) disable iff (!rst_n)
    ev_load |=> cnt == {$past(wdata_i), $past(latch_q[BYTE_W-1:0])});

  a_r4_load_arms: assert property (@(posedge clk) disable iff (!rst_n)
    ev_load |=> armed && !irq_flag_o);

  a_r2_latch_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_lat_lo || wr_lat_hi) && !ev_load && !tick_i) |=> $stable(cnt));

  a_r6_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ev_timeout |=> irq_flag_o);

  a_r5_flag_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_clr && !ev_timeout) |=> !irq_flag_o);

  a_r7_oneshot_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_timeout && !cfg_freerun_i) |=> !armed && cnt == {CNT_W{1'b1}});

  a_r8_freerun_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_timeout && cfg_freerun_i) |=> cnt == $past(latch_q));

  a_r9_pin_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_timeout && cfg_freerun_i) |=> pin_state != $past(pin_state));

  a_r9_pin_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_pin_en_i |-> pin_o);
endmodule

bind rtimer rtimer_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wdata_i(wdata_i),
  .cfg_freerun_i(cfg_freerun_i), .cfg_pin_en_i(cfg_pin_en_i),
  .irq_flag_o(irq_flag_o), .pin_o(pin_o), .wr_lat_lo(wr_lat_lo),
  .wr_lat_hi(wr_lat_hi), .ev_load(ev_load), .ev_clr(ev_clr),
  .ev_timeout(ev_timeout), .armed(armed), .pin_state(pin_state),
  .cnt(cnt), .latch_q(latch_q)
);

// File: tb/sim_rtimer.sv
`timescale 1ns/1ps
module sim_rtimer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0, sel_i = 1'b0, we_i = 1'b0;
  logic [1:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       cfg_freerun_i = 1'b0, cfg_pin_en_i = 1'b0;
  logic       irq_flag_o, pin_o;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  rtimer u0 (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); sel_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk); sel_i = 0; we_i = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); sel_i = 1; we_i = 0; addr_i = a;
    #1 d = rdata_o;
    @(negedge clk); sel_i = 0;
  endtask

  task automatic run_ticks(input int n);
    @(negedge clk); tick_i = 1;
    repeat (n) @(negedge clk);
    tick_i = 0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      chk("R1 reset register", 16'(d), 16'h0);
    end
    chk("R1 reset flag", 16'(irq_flag_o), 16'h0);
    chk("R1 reset pin", 16'(pin_o), 16'h1);
    run_ticks(10);
    chk("R1 no time-out before load", 16'(irq_flag_o), 16'h0);
  endtask

  task automatic t_oneshot;
    logic [7:0] d;
    cfg_freerun_i = 0; cfg_pin_en_i = 1;
    wr(2, 8'h05); wr(1, 8'h00);
    chk("R9 pin low after load", 16'(pin_o), 16'h0);
    run_ticks(5);
    chk("R6 no flag after N ticks", 16'(irq_flag_o), 16'h0);
    rd(0, d); chk("R6 count at zero", 16'(d), 16'h00);
    run_ticks(1);
    chk("R6 flag at tick N+1", 16'(irq_flag_o), 16'h1);
    chk("R9 one-shot pin high at time-out", 16'(pin_o), 16'h1);
    rd(1, d); chk("R7 wrap high byte", 16'(d), 16'hFF);
    rd(2, d); chk("R5 read low latch", 16'(d), 16'h05);
    rd(3, d); chk("R5 read high latch", 16'(d), 16'h00);
    chk("R5 reads 1..3 keep flag", 16'(irq_flag_o), 16'h1);
    wr(3, 8'h00);
    chk("R3 high latch write clears flag", 16'(irq_flag_o), 16'h0);
    run_ticks(20);
    chk("R7 no second flag", 16'(irq_flag_o), 16'h0);
    rd(0, d); chk("R7 keeps decrementing", 16'(d), 16'hEB);
  endtask

  task automatic t_freerun;
    logic [7:0] d;
    cfg_freerun_i = 1; cfg_pin_en_i = 1;
    wr(0, 8'h03); wr(1, 8'h00);
    chk("R9 pin low after load", 16'(pin_o), 16'h0);
    run_ticks(4);
    chk("R8 first time-out", 16'(irq_flag_o), 16'h1);
    chk("R9 pin inverts", 16'(pin_o), 16'h1);
    rd(0, d); chk("R8 reloaded count", 16'(d), 16'h03);
    chk("R5 low count read clears flag", 16'(irq_flag_o), 16'h0);
    run_ticks(3);
    chk("R8 no flag before period", 16'(irq_flag_o), 16'h0);
    run_ticks(1);
    chk("R8 second time-out", 16'(irq_flag_o), 16'h1);
    chk("R9 pin inverts again", 16'(pin_o), 16'h0);
    cfg_pin_en_i = 0; #1;
    chk("R9 disabled pin high", 16'(pin_o), 16'h1);
    cfg_freerun_i = 0;
  endtask

  task automatic t_latches;
    logic [7:0] d;
    wr(0, 8'h34); wr(1, 8'h12);
    wr(2, 8'h99); wr(0, 8'h77); wr(3, 8'hAB);
    rd(0, d); chk("R2 count low kept", 16'(d), 16'h34);
    rd(1, d); chk("R3 count high kept", 16'(d), 16'h12);
    rd(2, d); chk("R2 low latch", 16'(d), 16'h77);
    rd(3, d); chk("R3 high latch", 16'(d), 16'hAB);
  endtask

  task automatic t_load_tick;
    logic [7:0] d;
    @(negedge clk); tick_i = 1; sel_i = 1; we_i = 1; addr_i = 1; wdata_i = 8'h00;
    @(negedge clk); tick_i = 0; sel_i = 0; we_i = 0;
    rd(0, d); chk("R4 load ignores tick", 16'(d), 16'h77);
    wr(0, 8'h00); wr(1, 8'h01);
    run_ticks(1);
    rd(0, d); chk("R6 borrow low byte", 16'(d), 16'hFF);
    rd(1, d); chk("R6 borrow high byte", 16'(d), 16'h00);
  endtask

  task automatic t_collision;
    logic [7:0] d;
    cfg_freerun_i = 0;
    wr(0, 8'h00); wr(1, 8'h00);
    @(negedge clk); tick_i = 1; sel_i = 1; we_i = 0; addr_i = 0;
    #1 d = rdata_o;
    @(negedge clk); tick_i = 0; sel_i = 0;
    chk("R5 read returns count", 16'(d), 16'h00);
    chk("R6 time-out beats clear", 16'(irq_flag_o), 16'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_oneshot();
    t_freerun();
    t_latches();
    t_load_tick();
    t_collision();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule